// File: doc/BRIEF.md
# Carry-Save Power-of-Two Butterfly for Fermat-Modulus Transforms

This block is one radix-2 butterfly stage for a number-theoretic transform taken modulo 2^W+1, where every twiddle factor is a power of two. Both operands and both results stay in redundant form: each is a pair of W-bit vectors, and each vector is a diminished-1 code. No carry has to run across the word anywhere in the block. A transform engine chains several of these stages. A single carry-propagate adder sits after the last stage, and operand reordering between stages is handled outside this block.

The second operand is scaled by 2^i with wiring and inverters alone: a rotation in which the bits that wrap around are complemented. For amounts of W and above, the scaled value is also fully complemented, since 2^W is congruent to -1. The block then feeds two modulo 2^W+1 4-to-2 compressors. One takes the first operand with the scaled operand. The other takes the first operand with the complement of the scaled operand, which forms the difference. Each compressor is two carry-save layers whose end-around carry is inverted. The result pairs are registered, one cycle after the input strobe.

Top module: `fnt_dm1_butterfly`

## Requirements
- R1: A pair (s, c) denotes the residue (s + c + 2) mod 2^W+1. The pair on sum_s/sum_c denotes X + 2^i·Y, where X is the value of pair x_s/x_c, Y is the value of pair y_s/y_c, and i is shamt.
- R2: The pair on dif_s/dif_c denotes X − 2^i·Y mod 2^W+1.
- R3: For W ≤ shamt ≤ 2W−1, both results equal those for twiddle −2^(shamt−W). In particular, shamt = W yields sum X − Y and difference X + Y.
- R4: With shamt = 0, the sum pair denotes X + Y and the difference pair denotes X − Y.
- R5: Any shamt of 2W or more acts as shamt − 2W, because 2^(2W) ≡ 1.
- R6: out_vld is high in exactly those cycles that follow a cycle with in_vld high.
- R7: While rst_n is low, out_vld and all four result vectors are zero.
- R8: After a cycle with in_vld low, all four result vectors keep their previous values.
- R9: The value of the sum pair plus the value of the difference pair equals 2·X mod 2^W+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input strobe; results are captured when high |
| x_s | input | W | First operand, sum vector |
| x_c | input | W | First operand, carry vector |
| y_s | input | W | Second operand, sum vector |
| y_c | input | W | Second operand, carry vector |
| shamt | input | clog2(2W) | Twiddle exponent i |
| out_vld | output | 1 | Result strobe, one cycle after in_vld |
| sum_s | output | W | X + 2^i·Y, sum vector |
| sum_c | output | W | X + 2^i·Y, carry vector |
| dif_s | output | W | X − 2^i·Y, sum vector |
| dif_c | output | W | X − 2^i·Y, carry vector |

## Verification
The bench resolves every result pair to a residue and compares it with integer arithmetic, so any error in the end-around carry polarity shows up as a constant offset of ±1 or ±2 on every result. The bench drives exponents 0 and W−1, which catch a rotation that drops or wrongly inverts the wrapped bits. It drives W through 2W−1, which expose a twiddle that forgets to negate and so returns the sum where the difference belongs. It drives exponents past 2W−1 on a width where they can occur; a design that does not fold them there gives a sign or magnitude off by a power of two. Operand vectors of all ones and all zeros test the code points where complementing is easiest to get wrong. Idle gaps between operations check that the registers neither clear nor capture without the strobe.

// File: rtl/fnt_bfly_pkg.sv
package fnt_bfly_pkg;

   // number of result lanes: sum and difference
   localparam int LANES = 2;

   // lane index of the difference path (its twiddle is complemented)
   localparam int LANE_DIF = 1;

   // the multiplier 2^i has period 2W modulo 2^W+1; one subtraction suffices
   // because 2^clog2(2W) < 4W
   function automatic int fold_shift(input int sh, input int w);
      return (sh >= 2 * w) ? sh - 2 * w : sh;
   endfunction

endpackage

// File: rtl/dm1_csa3.sv
module dm1_csa3 #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] e,
   output logic [W-1:0] s,
   output logic [W-1:0] c
);
   logic [W-1:0] maj;

   assign s   = a ^ b ^ e;
   assign maj = (a & b) | (a & e) | (b & e);
   // carry moves up one place; the carry leaving the top returns inverted
   assign c   = {maj[W-2:0], ~maj[W-1]};
endmodule

// File: rtl/dm1_pow2_twiddle.sv
module dm1_pow2_twiddle #(
   parameter int W   = 8,
   parameter int SHW = 4
) (
   input  logic [W-1:0]   x,
   input  logic [SHW-1:0] rot,
   input  logic           neg,
   output logic [W-1:0]   w
);
   localparam int DW = 2 * W;

   logic [DW-1:0] dbl_sh;

   // upper half after the shift: low bits of x moved up, top bits of x
   // complemented and dropped in at the bottom
   assign dbl_sh = {x, ~x} << rot;
   assign w      = dbl_sh[DW-1:W] ^ {W{neg}};
endmodule

// File: rtl/dm1_mod_compress42.sv
module dm1_mod_compress42 #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   input  logic [W-1:0] d,
   output logic [W-1:0] s,
   output logic [W-1:0] k
);
   logic [W-1:0] l1_s;
   logic [W-1:0] l1_c;

   dm1_csa3 #(.W(W)) u_lay1 (
      .a (a),
      .b (b),
      .e (c),
      .s (l1_s),
      .c (l1_c)
   );

   dm1_csa3 #(.W(W)) u_lay2 (
      .a (l1_s),
      .b (l1_c),
      .e (d),
      .s (s),
      .c (k)
   );
endmodule

// File: rtl/fnt_dm1_butterfly.sv
module fnt_dm1_butterfly #(
   parameter int W       = 8,
   parameter bit REG_OUT = 1'b1,
   localparam int SHW    = $clog2(2 * W)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_vld,
   input  logic [W-1:0]   x_s,
   input  logic [W-1:0]   x_c,
   input  logic [W-1:0]   y_s,
   input  logic [W-1:0]   y_c,
   input  logic [SHW-1:0] shamt,
   output logic           out_vld,
   output logic [W-1:0]   sum_s,
   output logic [W-1:0]   sum_c,
   output logic [W-1:0]   dif_s,
   output logic [W-1:0]   dif_c
);
   import fnt_bfly_pkg::*;

   if (W < 2) begin : g_bad_width
      $error("fnt_dm1_butterfly: W must be at least 2");
   end

   logic [SHW-1:0] rot;
   logic           neg;
   logic [W-1:0]   y_vec [LANES];
   logic [W-1:0]   w_vec [LANES];
   logic [W-1:0]   r_s   [LANES];
   logic [W-1:0]   r_k   [LANES];

   always_comb begin
      int i_mod;
      i_mod = fold_shift(int'(shamt), W);
      neg   = (i_mod >= W);
      rot   = neg ? SHW'(i_mod - W) : SHW'(i_mod);
   end

   assign y_vec[0] = y_s;
   assign y_vec[1] = y_c;

   for (genvar v = 0; v < LANES; v++) begin : g_tw
      dm1_pow2_twiddle #(.W(W), .SHW(SHW)) u_tw (
         .x   (y_vec[v]),
         .rot (rot),
         .neg (neg),
         .w   (w_vec[v])
      );
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam bit INV = (g == LANE_DIF);
      dm1_mod_compress42 #(.W(W)) u_cmp (
         .a (x_s),
         .b (x_c),
         .c (w_vec[0] ^ {W{INV}}),
         .d (w_vec[1] ^ {W{INV}}),
         .s (r_s[g]),
         .k (r_k[g])
      );
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_vld <= 1'b0;
            sum_s   <= '0;
            sum_c   <= '0;
            dif_s   <= '0;
            dif_c   <= '0;
         end else begin
            out_vld <= in_vld;
            if (in_vld) begin
               sum_s <= r_s[0];
               sum_c <= r_k[0];
               dif_s <= r_s[LANE_DIF];
               dif_c <= r_k[LANE_DIF];
            end
         end
      end
   end else begin : g_comb
      assign out_vld = in_vld;
      assign sum_s   = r_s[0];
      assign sum_c   = r_k[0];
      assign dif_s   = r_s[LANE_DIF];
      assign dif_c   = r_k[LANE_DIF];
   end
endmodule

// File: rtl/fnt_dm1_butterfly_chk.sv
module fnt_dm1_butterfly_chk #(
   parameter int W       = 8,
   parameter bit REG_OUT = 1'b1,
   localparam int SHW    = $clog2(2 * W)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_vld,
   input logic [W-1:0]   x_s,
   input logic [W-1:0]   x_c,
   input logic [W-1:0]   y_s,
   input logic [W-1:0]   y_c,
   input logic [SHW-1:0] shamt,
   input logic           out_vld,
   input logic [W-1:0]   sum_s,
   input logic [W-1:0]   sum_c,
   input logic [W-1:0]   dif_s,
   input logic [W-1:0]   dif_c
);
   localparam longint MOD = (longint'(1) << W) + 1;

   function automatic longint res(input logic [W-1:0] s, input logic [W-1:0] c);
      return (longint'(s) + longint'(c) + 2) % MOD;
   endfunction

   if (REG_OUT) begin : g_chk
      assert_vld_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld |=> out_vld);

      assert_vld_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !in_vld |=> !out_vld);

      assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !in_vld |=> ($stable(sum_s) && $stable(sum_c) && $stable(dif_s) && $stable(dif_c)));

      assert_sum_dif_R9: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld |=> ((res(sum_s, sum_c) + res(dif_s, dif_c)) % MOD
                     == (2 * res($past(x_s), $past(x_c))) % MOD));

      assert_zero_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (in_vld && shamt == '0) |=> (res(sum_s, sum_c)
            == (res($past(x_s), $past(x_c)) + res($past(y_s), $past(y_c))) % MOD));

      assert_neg_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (in_vld && shamt == SHW'(W)) |=> (res(sum_s, sum_c)
            == (res($past(x_s), $past(x_c)) + MOD - res($past(y_s), $past(y_c))) % MOD));

      always @(negedge clk) begin
         if (!rst_n) begin
            assert_reset_clear_R7: assert (!out_vld && sum_s == '0 && sum_c == '0
                                           && dif_s == '0 && dif_c == '0);
         end
      end
   end
endmodule

bind fnt_dm1_butterfly fnt_dm1_butterfly_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .in_vld  (in_vld),
   .x_s     (x_s),
   .x_c     (x_c),
   .y_s     (y_s),
   .y_c     (y_c),
   .shamt   (shamt),
   .out_vld (out_vld),
   .sum_s   (sum_s),
   .sum_c   (sum_c),
   .dif_s   (dif_s),
   .dif_c   (dif_c)
);

// File: tb/tb_fnt_dm1_butterfly.sv
`timescale 1ns/1ps
module tb_fnt_dm1_butterfly;
   localparam int     W   = 6;
   localparam int     SHW = $clog2(2 * W);
   localparam longint MOD = (longint'(1) << W) + 1;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_vld = 1'b0;
   logic [W-1:0]   x_s = '0, x_c = '0, y_s = '0, y_c = '0;
   logic [SHW-1:0] shamt = '0;
   logic           out_vld;
   logic [W-1:0]   sum_s, sum_c, dif_s, dif_c;

   fnt_dm1_butterfly #(.W(W)) dut (
      .clk (clk), .rst_n (rst_n), .in_vld (in_vld),
      .x_s (x_s), .x_c (x_c), .y_s (y_s), .y_c (y_c), .shamt (shamt),
      .out_vld (out_vld), .sum_s (sum_s), .sum_c (sum_c),
      .dif_s (dif_s), .dif_c (dif_c)
   );

   always #2.5 clk = ~clk;

   typedef struct {
      int     cyc;
      bit     vld;
      longint ex;
      longint es;
      longint ed;
      string  tag_s;
      string  tag_d;
   } item_t;

   item_t q[$];
   int    cyc = 0;
   int    n_chk = 0;
   int    n_bad = 0;
   bit    mon_on = 1'b0;
   bit    done = 1'b0;
   logic [W-1:0] p_ss = '0, p_sc = '0, p_ds = '0, p_dc = '0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic longint res(input logic [W-1:0] s, input logic [W-1:0] c);
      return (longint'(s) + longint'(c) + 2) % MOD;
   endfunction

   function automatic longint pw2(input int i);
      longint t = 1;
      for (int k = 0; k < i; k++) t = (t * 2) % MOD;
      return t;
   endfunction

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic send(input bit v, input logic [W-1:0] xs, input logic [W-1:0] xc,
                       input logic [W-1:0] ys, input logic [W-1:0] yc,
                       input logic [SHW-1:0] sh, input string ts, input string td);
      item_t it;
      longint xv, yv, t;
      @(negedge clk);
      in_vld = v; x_s = xs; x_c = xc; y_s = ys; y_c = yc; shamt = sh;
      xv = res(xs, xc);
      yv = res(ys, yc);
      t  = (pw2(int'(sh)) * yv) % MOD;
      it.cyc = cyc; it.vld = v; it.ex = xv;
      it.es = (xv + t) % MOD;
      it.ed = (xv + MOD - t) % MOD;
      it.tag_s = ts; it.tag_d = td;
      q.push_back(it);
   endtask

   task automatic send_rnd(input logic [SHW-1:0] sh, input string ts, input string td);
      send(1'b1, W'($urandom), W'($urandom), W'($urandom), W'($urandom), sh, ts, td);
   endtask

   task automatic idle();
      send(1'b0, W'($urandom), W'($urandom), W'($urandom), W'($urandom),
           SHW'($urandom), "R8", "R8");
   endtask

   // monitor: checks each item one cycle after it was driven
   always @(negedge clk) begin
      if (mon_on) begin
         while (q.size() > 0 && q[0].cyc < cyc) begin
            item_t it;
            it = q.pop_front();
            if (it.vld) begin
               chk("R6 out_vld after strobe", longint'(out_vld), 1);
               chk({it.tag_s, " sum"}, res(sum_s, sum_c), it.es);
               chk({it.tag_d, " dif"}, res(dif_s, dif_c), it.ed);
               chk("R9 sum+dif", (res(sum_s, sum_c) + res(dif_s, dif_c)) % MOD,
                   (2 * it.ex) % MOD);
            end else begin
               chk("R6 out_vld idle", longint'(out_vld), 0);
               chk("R8 hold", longint'(sum_s == p_ss && sum_c == p_sc &&
                                       dif_s == p_ds && dif_c == p_dc), 1);
            end
         end
         p_ss = sum_s; p_sc = sum_c; p_ds = dif_s; p_dc = dif_c;
      end
   end

   initial begin
      in_vld = 1'b1;
      x_s = '1; x_c = '1; y_s = '1; y_c = '1;
      repeat (4) @(negedge clk);
      chk("R7 out_vld in reset", longint'(out_vld), 0);
      chk("R7 sum_s in reset", longint'(sum_s), 0);
      chk("R7 sum_c in reset", longint'(sum_c), 0);
      chk("R7 dif_s in reset", longint'(dif_s), 0);
      chk("R7 dif_c in reset", longint'(dif_c), 0);
      in_vld = 1'b0;
      rst_n = 1'b1;
      mon_on = 1'b1;

      // R4: no scaling
      send(1'b1, '0, '0, '0, '0, '0, "R4", "R4");
      send(1'b1, '1, '1, '1, '1, '0, "R4", "R4");
      for (int k = 0; k < 6; k++) send_rnd('0, "R4", "R4");
      idle(); idle();
      // R1 / R2: plain twiddles, including the top plain exponent
      for (int i = 1; i < W; i++) begin
         send(1'b1, '1, '0, '0, '1, SHW'(i), "R1", "R2");
         send(1'b1, W'(1), '0, '1, '1, SHW'(i), "R1", "R2");
         send_rnd(SHW'(i), "R1", "R2");
      end
      idle();
      // R3: negated twiddles
      for (int i = W; i < 2 * W; i++) begin
         send(1'b1, '0, '0, '1, '0, SHW'(i), "R3", "R3");
         send(1'b1, '1, '1, '0, '0, SHW'(i), "R3", "R3");
         send_rnd(SHW'(i), "R3", "R3");
      end
      idle();
      // R5: exponents past 2W-1 fold back
      for (int i = 2 * W; i < (1 << SHW); i++) begin
         send(1'b1, '1, '0, '1, '1, SHW'(i), "R5", "R5");
         send_rnd(SHW'(i), "R5", "R5");
         idle();
      end
      // mixed traffic with gaps
      for (int k = 0; k < 300; k++) begin
         if ($urandom_range(0, 3) == 0) idle();
         else send_rnd(SHW'($urandom_range(0, 2 * W - 1)), "R1", "R2");
      end
      idle(); idle(); idle();
      repeat (3) @(negedge clk);
      chk("R6 scoreboard drained", longint'(q.size()), 0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule